// File: doc/BRIEF.md
# Clock Buffer Configuration Serial Slave

This block is the configuration port of a differential clock buffer. It watches a two-wire serial bus (clock SCL, data SDA) by oversampling both lines with a fast system clock. It answers block-style transfers at one fixed 7-bit device address. The block holds six 8-bit configuration bytes and drives ten output-enable signals, one per differential clock pair.

A write transfer has four parts: the address with R/W = 0, a command byte, a count byte, then data. The slave acknowledges the command and count bytes and then discards them. Data always fills the configuration bytes from byte 0 upward, and no register address is involved. A read transfer with R/W = 1 returns a count of six followed by the six bytes. The open-drain SDA line is split into a sampled input and a drive-low output. The enable outputs follow the stored bytes as soon as each data byte is complete.

Top module: `clkbuf_cfg_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read) by pulling SDA low during the ninth SCL pulse. For any other address it gives no acknowledge, and it leaves SDA released for the rest of that transfer.
- R2: In a write, the slave acknowledges the first two bytes after the address and discards them. Each following byte is acknowledged and stored in configuration byte 0, then byte 1, and so on upward.
- R3: If the host stops a write after any complete data byte, every configuration byte not yet reached keeps its previous value.
- R4: Write data bytes after the sixth are acknowledged, and they leave every configuration byte unchanged.
- R5: A read returns the count value 6 first and then configuration bytes 0 through 5. Each byte is sent most significant bit first, and the host acknowledges each one.
- R6: If the host does not acknowledge a read byte, the slave releases SDA. It does not drive SDA again until a start or stop condition.
- R7: After reset, configuration bytes 0, 1, 2, 3 and 5 read 0xFF and byte 4 reads 0x06. All ten enables are 1 after reset.
- R8: Enable mapping (1 = enabled): pair 8 is byte 0 bit 7 and pair 9 is byte 0 bit 6. Pair k, for k = 0 to 7, is byte 5 bit (7-k).
- R9: The enables change only when a data byte completes, and they reflect that byte before the stop condition arrives.
- R10: A stop or start condition in the middle of a byte ends the transfer, and the partial byte is not stored. Bytes completed before it remain stored.
- R11: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as sampled |
| sda_i | input | 1 | Serial data line as sampled |
| sda_drive_low_o | output | 1 | 1 pulls SDA low; 0 releases it |
| pair_en_o | output | 10 | Output-enable per differential clock pair |

## Verification
A change on SCL or SDA reaches the protocol logic about three system clocks later: two synchronizer flops, then one edge-detect stage. The SDA drive register adds one more clock, so the slave's acknowledge and data bits settle about four clocks after the SCL falling edge that triggers them. Configuration bytes and enables update one clock after the eighth falling edge of a data byte. The bench holds every SCL phase for eight clocks and samples SDA and the enables only at the end of a phase. Each sample therefore falls well after the result is due and before the next bus edge.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  localparam int NUM_REGS = 6;
  localparam int BYTE_W   = 8;
  localparam int REG_IDXW = $clog2(NUM_REGS);
  localparam int SEQ_W    = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT
  } bus_st_e;

  function automatic logic [BYTE_W-1:0] reg_default(int idx);
    return (idx == 4) ? 8'h06 : 8'hFF;
  endfunction
endpackage

// File: rtl/cfgs_line_sampler.sv
module cfgs_line_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_sync_q, sda_sync_q;
  logic       scl_d_q, sda_d_q;

  // lines idle high: reset all stages to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= 2'b11;
      sda_sync_q <= 2'b11;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[0], scl_i};
      sda_sync_q <= {sda_sync_q[0], sda_i};
      scl_d_q    <= scl_sync_q[1];
      sda_d_q    <= sda_sync_q[1];
    end
  end

  assign scl_s_o    = scl_sync_q[1];
  assign sda_s_o    = sda_sync_q[1];
  assign scl_rise_o = scl_sync_q[1] & ~scl_d_q;
  assign scl_fall_o = ~scl_sync_q[1] & scl_d_q;
  assign start_o    = scl_sync_q[1] & scl_d_q & sda_d_q & ~sda_sync_q[1];
  assign stop_o     = scl_sync_q[1] & scl_d_q & ~sda_d_q & sda_sync_q[1];
endmodule

// File: rtl/cfgs_reg_file.sv
module cfgs_reg_file
  import cfgs_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [REG_IDXW-1:0]              wr_idx_i,
  input  logic [BYTE_W-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                         regs_o[g] <= reg_default(g);
      else if (wr_en_i && (wr_idx_i == REG_IDXW'(g)))      regs_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/cfgs_bus_engine.sv
module cfgs_bus_engine
  import cfgs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sda_i,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic [BYTE_W-1:0]   rd_data_i,
  output logic [REG_IDXW-1:0] rd_idx_o,
  output logic                wr_en_o,
  output logic [REG_IDXW-1:0] wr_idx_o,
  output logic [BYTE_W-1:0]   wr_data_o,
  output logic                sda_drive_low_o
);
  // write sequence: 0 = command, 1 = count, 2.. = data
  localparam logic [SEQ_W-1:0] DATA_BASE = SEQ_W'(2);
  localparam logic [SEQ_W-1:0] DATA_END  = SEQ_W'(2 + NUM_REGS);
  localparam logic [SEQ_W-1:0] RD_LAST   = SEQ_W'(NUM_REGS);

  bus_st_e           state_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic [SEQ_W-1:0]  idx_q, idx_nxt;
  logic              is_addr_q, rd_mode_q, host_ack_q, drive_q;
  logic              byte_done;
  logic [BYTE_W-1:0] tx_byte;

  assign idx_nxt   = (idx_q == '1) ? idx_q : idx_q + 1'b1;
  assign byte_done = (state_q == ST_RX) && scl_fall_i && (bit_cnt_q == 4'd8);

  // read sequence: 0 = count, 1..NUM_REGS = registers, then all ones
  assign rd_idx_o = REG_IDXW'(idx_q - 1'b1);
  always_comb begin
    if (idx_q == '0)          tx_byte = BYTE_W'(NUM_REGS);
    else if (idx_q <= RD_LAST) tx_byte = rd_data_i;
    else                      tx_byte = '1;
  end

  assign wr_en_o   = byte_done && !is_addr_q && (idx_q >= DATA_BASE) && (idx_q < DATA_END);
  assign wr_idx_o  = REG_IDXW'(idx_q - DATA_BASE);
  assign wr_data_o = shift_q;
  assign sda_drive_low_o = drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      shift_q    <= '0;
      idx_q      <= '0;
      is_addr_q  <= 1'b0;
      rd_mode_q  <= 1'b0;
      host_ack_q <= 1'b0;
      drive_q    <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_RX;
      is_addr_q <= 1'b1;
      rd_mode_q <= 1'b0;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      drive_q   <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i) begin
            shift_q   <= {shift_q[BYTE_W-2:0], sda_i};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_done) begin
            if (is_addr_q) begin
              if (shift_q[7:1] == DEV_ADDR) begin
                drive_q   <= 1'b1;
                rd_mode_q <= shift_q[0];
                is_addr_q <= 1'b0;
                state_q   <= ST_ACK;
              end else begin
                state_q <= ST_WAIT;
              end
            end else begin
              drive_q <= 1'b1;
              idx_q   <= idx_nxt;
              state_q <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            bit_cnt_q <= '0;
            if (rd_mode_q) begin
              shift_q <= tx_byte;
              drive_q <= ~tx_byte[7];
              idx_q   <= idx_nxt;
              state_q <= ST_TX;
            end else begin
              drive_q <= 1'b0;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bit_cnt_q == 4'd7) begin
              drive_q <= 1'b0;
              state_q <= ST_TXACK;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
              shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
              drive_q   <= ~shift_q[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise_i) begin
            host_ack_q <= ~sda_i;
          end else if (scl_fall_i) begin
            if (host_ack_q) begin
              bit_cnt_q <= '0;
              shift_q   <= tx_byte;
              drive_q   <= ~tx_byte[7];
              idx_q     <= idx_nxt;
              state_q   <= ST_TX;
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/clkbuf_cfg_slave.sv
module clkbuf_cfg_slave
  import cfgs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_PAIRS = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_drive_low_o,
  output logic [NUM_PAIRS-1:0] pair_en_o
);
  // pairs 0..7 from byte 5 (bit 7 first); pairs 8.. from byte 0 (bit 7 down)
  localparam int LO_PAIRS = 8;
  localparam int LO_REG   = 5;
  localparam int HI_REG   = 0;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                             wr_en;
  logic [REG_IDXW-1:0]              wr_idx, rd_idx;
  logic [BYTE_W-1:0]                wr_data, rd_data;
  logic [NUM_REGS-1:0][BYTE_W-1:0]  regs;

  cfgs_line_sampler i_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  cfgs_bus_engine #(.DEV_ADDR(DEV_ADDR)) i_engine (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sda_i           (sda_s),
    .scl_rise_i      (scl_rise),
    .scl_fall_i      (scl_fall),
    .start_i         (start_det),
    .stop_i          (stop_det),
    .rd_data_i       (rd_data),
    .rd_idx_o        (rd_idx),
    .wr_en_o         (wr_en),
    .wr_idx_o        (wr_idx),
    .wr_data_o       (wr_data),
    .sda_drive_low_o (sda_drive_low_o)
  );

  cfgs_reg_file i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .regs_o    (regs)
  );

  assign rd_data = (int'(rd_idx) < NUM_REGS) ? regs[rd_idx] : '1;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_en
    if (p < LO_PAIRS) begin : g_lo
      assign pair_en_o[p] = regs[LO_REG][BYTE_W-1-p];
    end else begin : g_hi
      assign pair_en_o[p] = regs[HI_REG][BYTE_W-1-(p-LO_PAIRS)];
    end
  end
endmodule

// File: rtl/clkbuf_cfg_slave_chk.sv
module clkbuf_cfg_slave_chk
  import cfgs_pkg::*;
#(
  parameter int NUM_PAIRS = 10
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 scl_s,
  input logic                 start_det,
  input logic                 stop_det,
  input logic                 sda_drive_low_o,
  input logic                 wr_en,
  input logic [REG_IDXW-1:0]  wr_idx,
  input logic [NUM_PAIRS-1:0] pair_en_o
);
  // R11
  drive_low_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_low_o) |-> !scl_s);

  // R10
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_drive_low_o);

  // R10
  start_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_drive_low_o);

  // R4
  wr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (int'(wr_idx) < NUM_REGS));

  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en |=> $stable(pair_en_o));
endmodule

bind clkbuf_cfg_slave clkbuf_cfg_slave_chk #(.NUM_PAIRS(NUM_PAIRS)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .scl_s           (scl_s),
  .start_det       (start_det),
  .stop_det        (stop_det),
  .sda_drive_low_o (sda_drive_low_o),
  .wr_en           (wr_en),
  .wr_idx          (wr_idx),
  .pair_en_o       (pair_en_o)
);

// File: tb/test_clkbuf_cfg_slave.sv
`timescale 1ns/1ps
module test_clkbuf_cfg_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_line;
  logic sda_drive_low;
  logic [9:0] pair_en;

  int checks = 0;
  int errors = 0;
  int r11_bad = 0;
  bit done = 1'b0;
  logic [7:0] model [6];
  logic [7:0] wbuf [16];
  logic drv_prev = 1'b0;

  always #2 clk = ~clk;

  assign sda_line = ~(host_low | sda_drive_low);

  clkbuf_cfg_slave i_clkbuf_cfg_slave (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .scl_i           (scl),
    .sda_i           (sda_line),
    .sda_drive_low_o (sda_drive_low),
    .pair_en_o       (pair_en)
  );

  // R11 monitor: slave must begin pulling low only with SCL low
  always @(negedge clk) begin
    if (rst_ni && sda_drive_low && !drv_prev && scl) r11_bad++;
    drv_prev <= sda_drive_low;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_en();
    logic [9:0] e;
    for (int k = 0; k < 8; k++) e[k] = model[5][7-k];
    e[8] = model[0][7];
    e[9] = model[0][6];
    return e;
  endfunction

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_low = 1'b1; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    host_low = 1'b1; wq();
    scl = 1'b1; wq();
    host_low = 1'b0; wq(2);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      host_low = ~b[i]; wq();
      scl = 1'b1; wq(2);
      scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    host_low = 1'b0; wq();
    scl = 1'b1; wq();
    ack = ~sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl = 1'b1; wq();
      b[i] = sda_line; wq();
      scl = 1'b0;
    end
    host_low = give_ack; wq();
    scl = 1'b1; wq(2);
    scl = 1'b0; wq();
    host_low = 1'b0;
  endtask

  task automatic write_txn(input int n);
    bit ack;
    bus_start();
    send_byte(8'hD2, ack); chk(ack, "R1 write address ack", ack, 1);
    send_byte(8'($urandom), ack); chk(ack, "R2 command ack", ack, 1);
    send_byte(8'($urandom), ack); chk(ack, "R2 count ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack, (i < 6) ? "R2 data ack" : "R4 extra data ack", ack, 1);
      if (i < 6) model[i] = wbuf[i];
      chk(pair_en == exp_en(), "R9 enables after byte", pair_en, exp_en());
    end
    bus_stop();
  endtask

  task automatic read_check();
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, ack); chk(ack, "R1 read address ack", ack, 1);
    recv_byte(1'b1, b); chk(b == 8'd6, "R5 byte count", b, 6);
    for (int i = 0; i < 6; i++) begin
      recv_byte(1'b1, b);
      chk(b == model[i], "R5 read data", b, model[i]);
    end
    bus_stop();
    chk(pair_en == exp_en(), "R8 enable mapping", pair_en, exp_en());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    logic [7:0] a;
    void'($urandom(32'd4711));
    for (int i = 0; i < 6; i++) model[i] = (i == 4) ? 8'h06 : 8'hFF;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    wq();
    chk(pair_en == 10'h3FF, "R7 reset enables", pair_en, 10'h3FF);
    chk(sda_drive_low == 1'b0, "R7 reset sda released", sda_drive_low, 0);
    read_check();  // R7 defaults via read

    // R2 R8 R9 directed full write
    wbuf[0] = 8'h80; wbuf[1] = 8'h12; wbuf[2] = 8'h34;
    wbuf[3] = 8'h56; wbuf[4] = 8'h78; wbuf[5] = 8'hA5;
    write_txn(6);
    chk(pair_en == 10'b01_1010_0101, "R8 directed mapping", pair_en, 10'b01_1010_0101);
    read_check();

    // R3 partial write
    wbuf[0] = 8'h40; wbuf[1] = 8'h00;
    write_txn(2);
    read_check();

    // R4 overlong write
    for (int i = 0; i < 9; i++) wbuf[i] = 8'(8'h11 * (i + 1));
    write_txn(9);
    read_check();

    // R1 foreign addresses
    foreach (wbuf[i]) if (i < 2) begin
      a = (i == 0) ? 8'hA0 : 8'hD4;
      bus_start();
      send_byte(a, ack); chk(!ack, "R1 foreign address nack", ack, 0);
      send_byte(8'h00, ack); chk(!ack, "R1 no ack after foreign address", ack, 0);
      send_byte(8'h00, ack); chk(!ack, "R1 no ack after foreign address", ack, 0);
      bus_stop();
    end
    read_check();

    // R6 host nack on read
    bus_start();
    send_byte(8'hD3, ack); chk(ack, "R6 read address ack", ack, 1);
    recv_byte(1'b0, b); chk(b == 8'd6, "R6 count before nack", b, 6);
    recv_byte(1'b0, b); chk(b == 8'hFF, "R6 sda released after nack", b, 8'hFF);
    bus_stop();

    // R10 stop mid-byte
    wbuf[0] = 8'h3C;
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(wbuf[0], ack); model[0] = wbuf[0];
    send_bits(8'h00, 4);
    bus_stop();
    chk(pair_en == exp_en(), "R10 stop mid-byte enables", pair_en, exp_en());
    read_check();

    // R10 start mid-byte, then stop
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_bits(8'h00, 5);
    host_low = 1'b0; wq();
    scl = 1'b1; wq();
    host_low = 1'b1; wq();
    chk(sda_drive_low == 1'b0, "R10 released after start", sda_drive_low, 0);
    host_low = 1'b0; wq(2);
    read_check();

    // random transfers
    for (int t = 0; t < 18; t++) begin
      int kind = int'($urandom % 4);
      if (kind < 2) begin
        int n = int'($urandom % 9);
        for (int i = 0; i < 16; i++) wbuf[i] = 8'($urandom);
        write_txn(n);
      end else if (kind == 2) begin
        read_check();
      end else begin
        do a = 8'($urandom); while (a[7:1] == 7'h69);
        bus_start();
        send_byte(a, ack); chk(!ack, "R1 random foreign nack", ack, 0);
        bus_stop();
      end
    end
    read_check();

    chk(r11_bad == 0, "R11 drive starts only with SCL low", r11_bad, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule